// File: doc/BRIEF.md
# CPU Interrupt Request Front End

This block sits between the interrupt pins of an 8-bit processor core and the core's sequencer. It brings in an active-low, edge-triggered non-maskable request and an active-low, level-triggered maskable request. It also takes a synchronous indication that a software break is executing and the core's interrupt-disable bit. From these it raises one request line toward the core, together with the 16-bit address at which the service routine starts. The address comes straight from a parameter, so the core does not have to fetch it from a vector location.

Sources rank as follows: reset first, then the non-maskable request, then the maskable request, then the software break. A parameter selects whether the break uses its own start address or shares the maskable one. Once a request is raised, the source and the address are frozen until the core acknowledges the start of service. That acknowledgement retires the source being served. A separate registered flag reports a maskable request that is present while masked, so that a core idling in a wait-for-interrupt state can resume with the next instruction.

Top module: `cpu_irq_front`

## Requirements
- R1: While `rst` is high, `int_req` and `irq_held` are 0. On the first rising edge after `rst` falls, `int_req` rises with `svc_vec` equal to `VEC_RST`.
- R2: The reset request is served before any other source, even if a non-maskable edge and an unmasked maskable request are already pending.
- R3: A high-to-low transition of `nmi_n`, seen after a two-stage synchronizer, latches a request that is served with `VEC_NMI`. The request is raised no earlier than three rising edges after the transition. An `nmi_n` held low yields only one request.
- R4: A pending non-maskable request is served before a maskable request or a break.
- R5: `irq_n` low requests service with `VEC_IRQ` only while `int_mask` is 0. With `int_mask` at 1, no request is raised.
- R6: `brk_req` high requests service. The address is `VEC_BRK` when `BRK_OWN_VEC` is 1 and `VEC_IRQ` when it is 0. The break is not affected by `int_mask`.
- R7: When an unmasked maskable request and a break are pending together, the maskable request is served first.
- R8: While `int_req` is 1 and `svc_ack` is 0, `int_req` stays 1 and `svc_vec` holds its value. A cycle with `svc_ack` high while `int_req` is 1 makes `int_req` 0 after the next rising edge.
- R9: `irq_held` is 1 exactly when the synchronized `irq_n` is low and `int_mask` is 1, registered one cycle after those conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_n | input | 1 | Non-maskable request, active low, edge-triggered, asynchronous |
| irq_n | input | 1 | Maskable request, active low, level-triggered, asynchronous |
| brk_req | input | 1 | Software break executing (synchronous to clk) |
| int_mask | input | 1 | Interrupt-disable bit from the core's status word |
| svc_ack | input | 1 | Core acknowledges start of service of the pending request |
| int_req | output | 1 | Request to the core |
| svc_vec | output | VEC_W | Start address of the service routine |
| irq_held | output | 1 | Maskable request present but masked |

## Verification
The bench builds two copies side by side on the same stimulus. The main copy uses distinct start addresses for all four sources and a dedicated break address. The second copy has `BRK_OWN_VEC` at 0, so the bench can observe the shared break address during the same break event. The distinct addresses let the scoreboard tell every source apart. This makes the ranking between sources visible when several are held pending behind an unacknowledged request.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_RST  = 3'd1,
    SRC_NMI  = 3'd2,
    SRC_IRQ  = 3'd3,
    SRC_BRK  = 3'd4
  } irq_src_e;

  // Fixed ranking: reset, non-maskable, maskable, break.
  function automatic irq_src_e pick_src(input logic rst_p, input logic nmi_p,
                                        input logic irq_p, input logic brk_p);
    if (rst_p)      return SRC_RST;
    else if (nmi_p) return SRC_NMI;
    else if (irq_p) return SRC_IRQ;
    else if (brk_p) return SRC_BRK;
    else            return SRC_NONE;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int         W       = 2,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic lvl_n,
  input  logic clr,
  output logic pend
);
  logic prev_n;
  logic fall;

  assign fall = prev_n & ~lvl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_n <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_n <= lvl_n;
      if (fall)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  // R3: a detected falling edge always leaves a pending request behind
  a_r3_fall_sets: assert property (@(posedge clk) disable iff (rst)
    (prev_n && !lvl_n) |=> pend);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_front_pkg::*;
#(
  parameter int             VEC_W       = 16,
  parameter logic [VEC_W-1:0] VEC_RST   = '0,
  parameter logic [VEC_W-1:0] VEC_NMI   = '0,
  parameter logic [VEC_W-1:0] VEC_IRQ   = '0,
  parameter logic [VEC_W-1:0] VEC_BRK   = '0,
  parameter bit             BRK_OWN_VEC = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_pend,
  input  logic             irq_lvl,
  input  logic             int_mask,
  input  logic             brk_req,
  input  logic             svc_ack,
  output logic             nmi_clr,
  output logic             busy,
  output logic [VEC_W-1:0] vec
);
  localparam logic [VEC_W-1:0] BRK_TARGET = BRK_OWN_VEC ? VEC_BRK : VEC_IRQ;

  irq_src_e cur;
  irq_src_e win;
  logic     rst_pend;
  logic     retire;
  logic [VEC_W-1:0] win_vec;

  assign win     = pick_src(rst_pend, nmi_pend, irq_lvl & ~int_mask, brk_req);
  assign retire  = busy & svc_ack;
  assign nmi_clr = retire & (cur == SRC_NMI);

  always_comb begin
    unique case (win)
      SRC_RST: win_vec = VEC_RST;
      SRC_NMI: win_vec = VEC_NMI;
      SRC_IRQ: win_vec = VEC_IRQ;
      SRC_BRK: win_vec = BRK_TARGET;
      default: win_vec = vec;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cur      <= SRC_NONE;
      vec      <= '0;
      rst_pend <= 1'b1;
    end else if (busy) begin
      if (svc_ack) begin
        busy <= 1'b0;
        if (cur == SRC_RST) rst_pend <= 1'b0;
      end
    end else if (win != SRC_NONE) begin
      busy <= 1'b1;
      cur  <= win;
      vec  <= win_vec;
    end
  end

  // R8: request and address frozen until acknowledged
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !svc_ack) |=> (busy && $stable(vec)));

  // R8: acknowledge drops the request on the next edge
  a_r8_drop: assert property (@(posedge clk) disable iff (rst)
    (busy && svc_ack) |=> !busy);

  // R5: a maskable request is never granted while masked
  a_r5_unmasked_only: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && cur == SRC_IRQ) |-> $past(!int_mask));

  // R4: a pending non-maskable request beats maskable and break
  a_r4_nmi_first: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && $past(nmi_pend)) |-> (cur == SRC_RST || cur == SRC_NMI));
endmodule

// File: rtl/cpu_irq_front.sv
module cpu_irq_front
  import irq_front_pkg::*;
#(
  parameter int             VEC_W       = 16,
  parameter int             SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] VEC_RST   = 16'hFF00,
  parameter logic [VEC_W-1:0] VEC_NMI   = 16'hFE00,
  parameter logic [VEC_W-1:0] VEC_IRQ   = 16'hFD00,
  parameter logic [VEC_W-1:0] VEC_BRK   = 16'hFC00,
  parameter bit             BRK_OWN_VEC = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_n,
  input  logic             irq_n,
  input  logic             brk_req,
  input  logic             int_mask,
  input  logic             svc_ack,
  output logic             int_req,
  output logic [VEC_W-1:0] svc_vec,
  output logic             irq_held
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pins_s;
  logic            nmi_pend;
  logic            nmi_clr;
  logic            irq_lvl;

  irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({irq_n, nmi_n}),
    .dout (pins_s)
  );

  nmi_edge_latch u_nmi (
    .clk   (clk),
    .rst   (rst),
    .lvl_n (pins_s[0]),
    .clr   (nmi_clr),
    .pend  (nmi_pend)
  );

  // Level path gets one register so it lines up with the edge latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lvl  <= 1'b0;
      irq_held <= 1'b0;
    end else begin
      irq_lvl  <= ~pins_s[1];
      irq_held <= ~pins_s[1] & int_mask;
    end
  end

  irq_arbiter #(
    .VEC_W(VEC_W), .VEC_RST(VEC_RST), .VEC_NMI(VEC_NMI),
    .VEC_IRQ(VEC_IRQ), .VEC_BRK(VEC_BRK), .BRK_OWN_VEC(BRK_OWN_VEC)
  ) u_arb (
    .clk      (clk),
    .rst      (rst),
    .nmi_pend (nmi_pend),
    .irq_lvl  (irq_lvl),
    .int_mask (int_mask),
    .brk_req  (brk_req),
    .svc_ack  (svc_ack),
    .nmi_clr  (nmi_clr),
    .busy     (int_req),
    .vec      (svc_vec)
  );

  // R9: held flag only follows a masked cycle
  a_r9_held_needs_mask: assert property (@(posedge clk) disable iff (rst)
    irq_held |-> $past(int_mask));
endmodule

// File: tb/cpu_irq_front_test.sv
`timescale 1ns/1ps
module cpu_irq_front_test;
  localparam logic [15:0] V_RST = 16'hE000;
  localparam logic [15:0] V_NMI = 16'hE100;
  localparam logic [15:0] V_IRQ = 16'hE200;
  localparam logic [15:0] V_BRK = 16'hE300;

  logic clk = 1'b0;
  logic rst, nmi_n, irq_n, brk_req, int_mask, svc_ack;
  logic int_req, irq_held, int_req_s, irq_held_s;
  logic [15:0] svc_vec, svc_vec_s;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  cpu_irq_front #(.VEC_RST(V_RST), .VEC_NMI(V_NMI), .VEC_IRQ(V_IRQ),
                  .VEC_BRK(V_BRK), .BRK_OWN_VEC(1'b1)) uut (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .irq_n(irq_n), .brk_req(brk_req),
    .int_mask(int_mask), .svc_ack(svc_ack), .int_req(int_req),
    .svc_vec(svc_vec), .irq_held(irq_held));

  cpu_irq_front #(.VEC_RST(V_RST), .VEC_NMI(V_NMI), .VEC_IRQ(V_IRQ),
                  .VEC_BRK(V_BRK), .BRK_OWN_VEC(1'b0)) uut_shr (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .irq_n(irq_n), .brk_req(brk_req),
    .int_mask(int_mask), .svc_ack(svc_ack), .int_req(int_req_s),
    .svc_vec(svc_vec_s), .irq_held(irq_held_s));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops one expected address per new request.
  bit seen = 1'b0;
  always @(negedge clk) begin
    if (!rst && int_req && !seen) begin
      seen = 1'b1;
      if (exp_q.size() == 0) check(1'b0, "R1-scoreboard unexpected request", svc_vec, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(svc_vec == e, "R2/R4/R7 served address order", svc_vec, e);
      end
    end else if (!int_req) seen = 1'b0;
  end

  // Waits for a request, checks it holds, acknowledges.
  task automatic serve(input bit set_mask, input bit drop_brk);
    int w = 0;
    logic [15:0] v;
    while (!int_req && w < 12) begin tick(1); w++; end
    check(int_req == 1'b1, "R3 request within latency", int_req, 1);
    v = svc_vec;
    tick(3);
    check(int_req == 1'b1 && svc_vec == v, "R8 held until ack", svc_vec, v);
    svc_ack = 1'b1;
    if (set_mask) int_mask = 1'b1;
    if (drop_brk) brk_req = 1'b0;
    tick(1);
    svc_ack = 1'b0;
    check(int_req == 1'b0, "R8 drop after ack", int_req, 0);
  endtask

  initial begin
    rst = 1'b1; nmi_n = 1'b0; irq_n = 1'b0; brk_req = 1'b0;
    int_mask = 1'b0; svc_ack = 1'b0;
    tick(3);
    check(int_req == 1'b0, "R1 no request in reset", int_req, 0);
    check(irq_held == 1'b0, "R1 held flag clear in reset", irq_held, 0);
    exp_q.push_back(V_RST); exp_q.push_back(V_NMI); exp_q.push_back(V_IRQ);
    rst = 1'b0;
    tick(1);
    check(int_req == 1'b1 && svc_vec == V_RST, "R1 reset request first edge", svc_vec, V_RST);
    serve(1'b0, 1'b0);            // R2 reset served first
    serve(1'b0, 1'b0);            // R4 NMI before IRQ
    serve(1'b1, 1'b0);            // R5 IRQ, core then masks
    tick(3);
    check(irq_held == 1'b1, "R9 held while masked", irq_held, 1);
    tick(8);
    check(int_req == 1'b0, "R3 held-low NMI gives one request", int_req, 0);
    check(int_req == 1'b0, "R5 masked IRQ gives no request", int_req, 0);
    nmi_n = 1'b1; irq_n = 1'b1;
    tick(5);
    check(irq_held == 1'b0, "R9 held clears when line idle", irq_held, 0);

    // fresh NMI edge
    exp_q.push_back(V_NMI);
    nmi_n = 1'b0;
    tick(2);
    check(int_req == 1'b0, "R3 not before synchronizer", int_req, 0);
    serve(1'b0, 1'b0);
    nmi_n = 1'b1;
    tick(4);

    // masked then unmasked IRQ
    int_mask = 1'b1; irq_n = 1'b0;
    tick(8);
    check(int_req == 1'b0, "R5 masked no request", int_req, 0);
    check(irq_held == 1'b1, "R9 masked IRQ flagged", irq_held, 1);
    exp_q.push_back(V_IRQ);
    int_mask = 1'b0;
    tick(2);
    check(irq_held == 1'b0, "R9 unmask clears flag", irq_held, 0);
    serve(1'b1, 1'b0);
    irq_n = 1'b1;
    tick(5);

    // BRK, with mask still set
    exp_q.push_back(V_BRK);
    brk_req = 1'b1;
    tick(2);
    check(int_req_s == 1'b1 && svc_vec_s == V_IRQ, "R6 shared break address", svc_vec_s, V_IRQ);
    check(svc_vec == V_BRK, "R6 own break address", svc_vec, V_BRK);
    serve(1'b0, 1'b1);
    tick(3);

    // IRQ and BRK pending behind an NMI
    exp_q.push_back(V_NMI); exp_q.push_back(V_IRQ); exp_q.push_back(V_BRK);
    nmi_n = 1'b0;
    tick(5);
    int_mask = 1'b0; irq_n = 1'b0; brk_req = 1'b1;
    tick(5);
    serve(1'b0, 1'b0);            // NMI
    serve(1'b1, 1'b0);            // R7 IRQ ahead of BRK
    serve(1'b0, 1'b1);            // then BRK despite mask
    nmi_n = 1'b1; irq_n = 1'b1;
    tick(5);
    check(exp_q.size() == 0, "R7 all expected requests seen", exp_q.size(), 0);
    check(int_req == 1'b0, "R8 idle at end", int_req, 0);
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 5000) begin @(posedge clk); n++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule